// File: doc/BRIEF.md
# Elementary Time Unit Divider with Half-Clock Compensation

This block turns the card clock into the elementary time unit (ETU) timebase used by a smart card serial engine. A 12-bit divider value sets the ETU length. In the plain mode every ETU lasts the divider value plus one clocks. In the compensated mode the block alternates between ETUs of n and n-1 clocks, so the average ETU falls half a clock below n. For that mode n is the programmed value.

Two single-cycle strobes leave the block. `etuTick` marks the last cycle of every ETU. `midTick` marks the middle cycle, where a receiver samples a bit. A synchronous `restart` input realigns the phase, for example on a detected start edge. After a restart the next cycle is the first cycle of a long ETU. Divider values below five are clamped to five. The divider value and the mode are sampled in the first cycle of each ETU, so a change made mid-ETU applies from the next ETU on.

Top module: `etu_divider`

## Requirements
- R1: With `compEn` low, every ETU lasts n+1 clocks and `etuTick` is high only in its last cycle, where n is the clamped divider value.
- R2: A `divVal` below 5 (values 0 to 4) behaves exactly like `divVal` = 5.
- R3: With `compEn` high, ETUs alternate between n and n-1 clocks. The first ETU after reset or restart is the long one (n).
- R4: While `restart` is high, both strobes are low. The cycle after a restart cycle is cycle 0 of a long ETU.
- R5: `midTick` is high only in cycle floor(L/2) of each ETU of length L, counting the ETU's first cycle as 0.
- R6: `divVal` and `compEn` are sampled only in cycle 0 of each ETU. A change made later in an ETU leaves that ETU's length unchanged and applies from the next ETU. A compensated sequence entered from plain mode starts with a long ETU.
- R7: During reset both strobes are low. The first cycle after reset release is cycle 0 of a long ETU.
- R8: The full 12-bit range works: `divVal` = 4095 yields 4096-clock ETUs in plain mode, and alternating 4095/4094-clock ETUs in compensated mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divVal | input | 12 | Programmed divider value n |
| compEn | input | 1 | Selects alternating n / n-1 compensation |
| restart | input | 1 | Synchronous phase restart |
| etuTick | output | 1 | High in the last cycle of each ETU |
| midTick | output | 1 | High in the middle cycle of each ETU |

## Verification
The embedded properties assume the clamp keeps every period at four clocks or more. Under that assumption the middle and last cycles of an ETU never coincide, and the counter always stays below the latched period. They also assume `restart` and the configuration inputs change only between clock edges. The bench drives all inputs at the falling edge, and it applies every configuration after a restart pulse or as a mid-ETU change. As a result, each period the bench predicts arithmetically starts from a known phase.

// File: rtl/etu_pkg.sv
package etu_pkg;
  // Strobes the control half sends to the counting datapath.
  typedef struct packed {
    logic clrCnt;   // return counter to cycle 0 of a new ETU
    logic loadPer;  // capture the live period for the ETU now starting
  } etuStrb_t;
endpackage

// File: rtl/etu_dp.sv
module etu_dp
  import etu_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int MIN_DIV = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic             compEn,
  input  logic             phaseShort,
  input  etuStrb_t         strb,
  output logic             isFirst,
  output logic             isLast,
  output logic             isMid
);
  localparam int PW = DIV_W + 1;
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
  localparam logic [PW-1:0] RST_PER = PW'(MIN_DIV + 1);

  logic [PW-1:0]    cnt;
  logic [PW-1:0]    curPer;
  logic [DIV_W-1:0] nEff;
  logic [PW-1:0]    nExt;
  logic [PW-1:0]    livePer;
  logic [PW-1:0]    perUse;

  // Clamp of illegal small dividers
  assign nEff = (divVal < MIN_V) ? MIN_V : divVal;
  assign nExt = {1'b0, nEff};

  always_comb begin
    if (compEn) livePer = phaseShort ? (nExt - PW'(1)) : nExt;
    else        livePer = nExt + PW'(1);
  end

  assign isFirst = (cnt == '0);
  assign perUse  = isFirst ? livePer : curPer;
  assign isLast  = (cnt == perUse - PW'(1));
  assign isMid   = (cnt == (perUse >> 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      curPer <= RST_PER;
    end else begin
      if (strb.loadPer) curPer <= livePer;
      if (strb.clrCnt)  cnt <= '0;
      else              cnt <= cnt + PW'(1);
    end
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    !isFirst |-> (cnt < curPer)) else $error("counter beyond period"); // R1
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPer |=> (curPer >= PW'(MIN_DIV - 1))) else $error("period under floor"); // R2
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !isFirst |=> $stable(curPer) || $past(strb.loadPer)) else $error("period moved mid-ETU"); // R6
endmodule

// File: rtl/etu_ctrl.sv
module etu_ctrl
  import etu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     restart,
  input  logic     compEn,
  input  logic     isFirst,
  input  logic     isLast,
  input  logic     isMid,
  output logic     phaseShort,
  output etuStrb_t strb,
  output logic     etuTick,
  output logic     midTick
);
  logic curComp;
  logic compUse;
  logic wrap;

  assign compUse = isFirst ? compEn : curComp;
  assign wrap    = isLast & ~restart;

  assign strb.clrCnt  = restart | isLast;
  assign strb.loadPer = isFirst;

  assign etuTick = wrap;
  assign midTick = isMid & ~restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseShort <= 1'b0;
      curComp    <= 1'b0;
    end else begin
      if (isFirst) curComp <= compEn;
      if (restart)   phaseShort <= 1'b0;
      else if (wrap) phaseShort <= compUse ? ~phaseShort : 1'b0;
    end
  end

  AST_STROBES_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    etuTick |-> !midTick) else $error("mid and last coincide"); // R5
  AST_COMP_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && curComp) |=> (phaseShort != $past(phaseShort))) else $error("no alternation"); // R3
  AST_RESTART_LONG: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!phaseShort && isFirst)) else $error("restart not long"); // R4
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> (!etuTick && !midTick)) else $error("strobe during restart"); // R4
endmodule

// File: rtl/etu_divider.sv
module etu_divider
  import etu_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int MIN_DIV = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic             compEn,
  input  logic             restart,
  output logic             etuTick,
  output logic             midTick
);
  etuStrb_t strb;
  logic isFirst, isLast, isMid, phaseShort;

  etu_dp #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) uDp (
    .clk(clk), .rstN(rstN), .divVal(divVal), .compEn(compEn),
    .phaseShort(phaseShort), .strb(strb),
    .isFirst(isFirst), .isLast(isLast), .isMid(isMid)
  );

  etu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .restart(restart), .compEn(compEn),
    .isFirst(isFirst), .isLast(isLast), .isMid(isMid),
    .phaseShort(phaseShort), .strb(strb),
    .etuTick(etuTick), .midTick(midTick)
  );
endmodule

// File: tb/tb_etu_divider.sv
module tb_etu_divider;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] divVal = 12'd7;
  logic compEn = 1'b0;
  logic restart = 1'b0;
  logic etuTick, midTick;

  int vecCnt = 0;
  int errCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  etu_divider dut (
    .clk(clk), .rstN(rstN), .divVal(divVal), .compEn(compEn),
    .restart(restart), .etuTick(etuTick), .midTick(midTick)
  );

  function automatic int lenOf(int d, bit c, bit sh);
    int n;
    n = (d < 5) ? 5 : d;
    if (!c) return n + 1;
    return sh ? n - 1 : n;
  endfunction

  task automatic check(string req, bit expT, bit expM);
    vecCnt++;
    if (etuTick !== expT || midTick !== expM) begin
      errCnt++;
      $display("FAIL %s: tick/mid actual %b%b expected %b%b (div=%0d comp=%0b)",
               req, etuTick, midTick, expT, expM, divVal, compEn);
    end
  endtask

  // Samples nEtu ETUs starting at cycle 0 of a long ETU. Config A is live
  // for ETU 0; config B is applied in cycle 2 of ETU 0 (R6).
  task automatic runEtus(string req, int dA, bit cA, int dB, bit cB, int nEtu);
    bit ph = 1'b0;
    int d = dA;
    bit c = cA;
    for (int j = 0; j < nEtu; j++) begin
      int len = lenOf(d, c, ph);
      for (int i = 0; i < len; i++) begin
        #1;
        check(req, i == len - 1, i == len / 2);
        @(negedge clk);
        if (j == 0 && i == 1) begin
          divVal = dB[11:0];
          compEn = cB;
        end
      end
      ph = c ? ~ph : 1'b0;
      d = dB;
      c = cB;
    end
  endtask

  task automatic restartRun(string req, int dA, bit cA, int dB, bit cB, int nEtu);
    repeat (3) @(negedge clk);
    divVal  = dA[11:0];
    compEn  = cA;
    restart = 1'b1;
    #1;
    check("R4", 1'b0, 1'b0);
    @(negedge clk);
    restart = 1'b0;
    runEtus(req, dA, cA, dB, cB, nEtu);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    // R7: quiet in reset, then the first ETU is long from cycle 0
    repeat (3) begin
      @(negedge clk);
      check("R7", 1'b0, 1'b0);
    end
    rstN = 1'b1;
    runEtus("R7", 7, 1'b0, 7, 1'b0, 3);

    // R1/R2/R3/R5: sweep divider 0..12 in both modes
    for (int d = 0; d <= 12; d++) begin
      restartRun(d < 5 ? "R2" : "R1", d, 1'b0, d, 1'b0, 4);
      restartRun(d < 5 ? "R2" : "R3", d, 1'b1, d, 1'b1, 5);
    end
    restartRun("R5", 100, 1'b0, 100, 1'b0, 2);
    restartRun("R5", 1000, 1'b1, 1000, 1'b1, 3);

    // R8: full-range divider
    restartRun("R8", 4095, 1'b0, 4095, 1'b0, 2);
    restartRun("R8", 4095, 1'b1, 4095, 1'b1, 3);

    // R6: mid-ETU changes take effect only at the next boundary
    restartRun("R6", 7, 1'b0, 20, 1'b0, 3);
    restartRun("R6", 20, 1'b1, 6, 1'b1, 4);
    restartRun("R6", 9, 1'b0, 9, 1'b1, 4);
    restartRun("R6", 9, 1'b1, 2, 1'b0, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule